// File: doc/BRIEF.md
# Interrupt Status and Vector Unit

This unit sits between the bus engine of a serial bus controller and the processor. Single-cycle event pulses from the engine set sticky status bits at fixed positions. An enable register selects which of the maskable events drive the one interrupt line. Software clears a status bit by writing a 1 to it.

A vector register is kept for older software. It reports the highest-priority pending enabled event as a small code, and reading it clears that event. The bus-busy indication is not sticky: it follows the engine's busy level, and writes have no effect on it.

The register interface is one cycle per access. Read data is combinational from the registered state. A write, or a clear caused by a read, takes effect at the clock edge that ends the access.

Top module: `evt_irq_unit`

## Requirements
- R1: After reset, the enable register reads 0, status reads 0 (bus busy aside), the vector reads 0 and `irq_o` is low.
- R2: A pulse on `evt_pulse_i` at bit 0 (arbitration lost), 1 (no acknowledge), 2 (access ready), 3 (receive ready), 4 (transmit ready), 8 (address zero), 9 (addressed as slave), 10 (transmit underflow), 11 (receive overrun), 13 (receive drain) or 14 (transmit drain) sets that status bit (address 1) until it is cleared. Status bits 5–7 and 15 always read 0.
- R3: Writing status with a 1 in a bit position clears that bit. A 0 in a bit position leaves the bit unchanged.
- R4: If an event pulse and a write-one clear hit the same bit in the same cycle, the bit stays set.
- R5: Status bit 12 shows `bus_busy_i` in the current cycle, and no write changes it.
- R6: The enable register (address 0) stores bits 0–4, 13 and 14. All its other bits read 0.
- R7: `irq_o` is the OR of status AND enable over bits 0–4, 13 and 14. It follows the registered state with no added delay. Status bits 8–12 never raise it.
- R8: With the enable register at 0, `irq_o` stays low whatever status holds.
- R9: The vector register (address 2) reads 0 when no enabled event in bits 0–4 is pending. Otherwise it reads status bit index + 1 of the lowest pending enabled bit: 1 arbitration lost, 2 no acknowledge, 3 access ready, 4 receive ready, 5 transmit ready.
- R10: Reading the vector clears only the status bit it reports. Reading a zero vector, reading status, or reading enable changes nothing.
- R11: Writes to the vector address have no effect on any state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_pulse_i | input | 16 | Event pulses from the bus engine, one bit per status position |
| bus_busy_i | input | 1 | Live bus-busy level |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | 2 | Register select: 0 enable, 1 status, 2 vector |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data for the selected register |
| irq_o | output | 1 | Interrupt request |

## Verification
Read data and the bus-busy bit are due in the same cycle as the access. The bench samples them a short delay after driving the strobe, before the next rising edge.

Status updates from pulses, writes and vector-read clears are due one edge later. `irq_o` follows that same edge. The bench therefore checks them only after the access cycle has closed.

The sweep covers every combination of the five coded events against every enable setting for those five bits. For each combination it compares status, `irq_o`, the vector code and the status after the read with values the bench computes itself.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;
  localparam int REG_W   = 16;
  localparam int NUM_VEC = 5;
  localparam int VEC_W   = $clog2(NUM_VEC + 1);
  localparam int BUSY_BIT = 12;

  // sticky status positions: 0-4, 8-11, 13-14
  localparam logic [REG_W-1:0] STICKY_MASK = 16'h6F1F;
  // positions that can raise the interrupt and are kept in the enable reg
  localparam logic [REG_W-1:0] IRQ_MASK    = 16'h601F;

  typedef enum logic [1:0] {
    A_ENABLE = 2'd0,
    A_STATUS = 2'd1,
    A_VECTOR = 2'd2,
    A_NONE   = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/evt_status_reg.sv
module evt_status_reg #(
  parameter int              W         = 16,
  parameter logic [W-1:0]    KEEP_MASK = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (KEEP_MASK[i]) begin : g_keep
      logic q_r, q_d, ce;
      always_comb begin
        ce  = set_i[i] | clr_i[i];
        q_d = set_i[i] | (q_r & ~clr_i[i]);
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  q_r <= 1'b0;
        else if (ce) q_r <= q_d;
      end
      assign q_o[i] = q_r;

      // R4: a pulse in the same cycle as a clear leaves the bit set
      p_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
        set_i[i] |=> q_o[i]);
      // R3: a write-one clear without a pulse empties the bit
      p_w1c_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i[i] && !set_i[i]) |=> !q_o[i]);
    end else begin : g_zero
      assign q_o[i] = 1'b0;
    end
  end
endmodule

// File: rtl/evt_vec_enc.sv
module evt_vec_enc #(
  parameter int N  = 5,
  parameter int CW = $clog2(N + 1)
) (
  input  logic [N-1:0]  req_i,
  output logic [CW-1:0] code_o,
  output logic [N-1:0]  grant_o
);
  // lowest index wins; code is index + 1, zero when nothing requests
  always_comb begin
    code_o  = '0;
    grant_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        code_o     = CW'(i + 1);
        grant_o    = '0;
        grant_o[i] = 1'b1;
      end
    end
  end

  // R9: at most one event is reported
  a_grant_onehot_r9: assert final ($onehot0(grant_o));
endmodule

// File: rtl/evt_irq_mask.sv
module evt_irq_mask #(
  parameter int           W       = 16,
  parameter logic [W-1:0] WR_MASK = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic [W-1:0] status_i,
  output logic [W-1:0] en_o,
  output logic         irq_o
);
  logic [W-1:0] en_r, en_d;

  always_comb en_d = wdata_i & WR_MASK;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    en_r <= '0;
    else if (wr_i) en_r <= en_d;
  end

  assign en_o  = en_r;
  assign irq_o = |(status_i & en_r);

  // R8: writing a zero enable silences the line from the next cycle
  p_mask_all_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && ((wdata_i & WR_MASK) == '0)) |=> !irq_o);
endmodule

// File: rtl/evt_irq_unit.sv
module evt_irq_unit
  import evt_irq_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_W-1:0]  evt_pulse_i,
  input  logic              bus_busy_i,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  output logic              irq_o
);
  logic [REG_W-1:0]   sticky_q, status_view, en_q, clr_vec, clr_all, set_all;
  logic [NUM_VEC-1:0] vec_req, vec_grant;
  logic [VEC_W-1:0]   vec_code;
  logic               wr_en, wr_stat, rd_vec;
  reg_sel_e           sel;

  always_comb begin
    sel     = reg_sel_e'(reg_addr_i);
    wr_en   = reg_wr_i && (sel == A_ENABLE);
    wr_stat = reg_wr_i && (sel == A_STATUS);
    rd_vec  = reg_rd_i && (sel == A_VECTOR);
  end

  always_comb begin
    clr_vec = '0;
    if (rd_vec) clr_vec[NUM_VEC-1:0] = vec_grant;
    clr_all = (wr_stat ? reg_wdata_i : '0) | clr_vec;
    set_all = evt_pulse_i & STICKY_MASK;
  end

  evt_status_reg #(.W(REG_W), .KEEP_MASK(STICKY_MASK)) u_stat (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (set_all),
    .clr_i (clr_all),
    .q_o   (sticky_q)
  );

  evt_irq_mask #(.W(REG_W), .WR_MASK(IRQ_MASK)) u_mask (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_i     (wr_en),
    .wdata_i  (reg_wdata_i),
    .status_i (sticky_q),
    .en_o     (en_q),
    .irq_o    (irq_o)
  );

  always_comb vec_req = sticky_q[NUM_VEC-1:0] & en_q[NUM_VEC-1:0];

  evt_vec_enc #(.N(NUM_VEC), .CW(VEC_W)) u_enc (
    .req_i   (vec_req),
    .code_o  (vec_code),
    .grant_o (vec_grant)
  );

  always_comb begin
    status_view           = sticky_q;
    status_view[BUSY_BIT] = bus_busy_i;
    case (sel)
      A_ENABLE: reg_rdata_o = en_q;
      A_STATUS: reg_rdata_o = status_view;
      A_VECTOR: reg_rdata_o = REG_W'(vec_code);
      default:  reg_rdata_o = '0;
    endcase
  end

  // R10: a vector read clears the reported bit unless it is re-pulsed
  p_vec_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_vec && vec_code != '0 && (evt_pulse_i[NUM_VEC-1:0] & vec_grant) == '0)
    |=> ((sticky_q[NUM_VEC-1:0] & $past(vec_grant)) == '0));
  // R11: a vector write with no other activity leaves all state alone
  p_vec_write_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_i && sel == A_VECTOR && !reg_rd_i && evt_pulse_i == '0)
    |=> ($stable(sticky_q) && $stable(en_q)));
  // R9: the code never exceeds the number of coded events
  p_code_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
    vec_code <= VEC_W'(NUM_VEC));
endmodule

// File: tb/sim_evt_irq_unit.sv
`timescale 1ns/1ps
module sim_evt_irq_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] evt_pulse = '0;
  logic        busy = 1'b0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [1:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        irq;
  int          n_tests = 0, n_fail = 0;
  bit          done = 0;

  always #4 clk = ~clk;

  evt_irq_unit u0 (
    .clk(clk), .rst_n(rst_n), .evt_pulse_i(evt_pulse), .bus_busy_i(busy),
    .reg_wr_i(wr), .reg_rd_i(rd), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_write(logic [1:0] a, logic [15:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0; wdata = '0;
  endtask

  task automatic reg_read(logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    rd = 1'b1; addr = a;
    #2 d = rdata;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic pulse(logic [15:0] m);
    @(negedge clk);
    evt_pulse = m;
    @(negedge clk);
    evt_pulse = '0;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic [15:0] v;
    logic [15:0] s;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1 chk("R1 irq", {15'd0, irq}, 16'd0);
    reg_read(2'd0, v); chk("R1 enable", v, 16'h0000);
    reg_read(2'd1, v); chk("R1 status", v, 16'h0000);
    reg_read(2'd2, v); chk("R1 vector", v, 16'h0000);

    // enable register writable bits
    reg_write(2'd0, 16'hFFFF);
    reg_read(2'd0, v); chk("R6 enable mask", v, 16'h601F);
    reg_write(2'd0, 16'h0F00);
    reg_read(2'd0, v); chk("R6 non-maskable bits", v, 16'h0000);

    // every event position, enable off
    pulse(16'hFFFF);
    reg_read(2'd1, v); chk("R2 all events sticky", v, 16'h6F1F);
    #1 chk("R8 masked irq", {15'd0, irq}, 16'd0);
    reg_read(2'd2, v); chk("R8 vector masked", v, 16'h0000);

    // partial W1C
    reg_write(2'd1, 16'h0105);
    reg_read(2'd1, v); chk("R3 write-one clear", v, 16'h6E1A);
    reg_read(2'd1, v); chk("R10 status read no side effect", v, 16'h6E1A);

    // non-maskable bits never raise irq
    reg_write(2'd1, 16'hFFFF);
    reg_write(2'd0, 16'h601F);
    pulse(16'h0F00);
    #1 chk("R7 bits 8-11 no irq", {15'd0, irq}, 16'd0);
    // drain event raises irq but has no vector code
    pulse(16'h2000);
    #1 chk("R7 drain irq", {15'd0, irq}, 16'd1);
    reg_read(2'd2, v); chk("R9 drain no code", v, 16'h0000);
    reg_read(2'd1, v); chk("R10 zero vector read no clear", v, 16'h2F00);
    reg_write(2'd1, 16'hFFFF);

    // set wins over clear in the same cycle
    @(negedge clk);
    wr = 1'b1; addr = 2'd1; wdata = 16'h0008; evt_pulse = 16'h0008;
    @(negedge clk);
    wr = 1'b0; wdata = '0; evt_pulse = '0;
    reg_read(2'd1, v); chk("R4 set wins", v, 16'h0008);
    #1 chk("R7 irq after set-wins", {15'd0, irq}, 16'd1);

    // vector writes ignored
    reg_write(2'd2, 16'hFFFF);
    reg_read(2'd1, v); chk("R11 vector write status", v, 16'h0008);
    reg_read(2'd0, v); chk("R11 vector write enable", v, 16'h601F);
    reg_write(2'd1, 16'hFFFF);

    // bus busy is a live level
    @(negedge clk); busy = 1'b1;
    reg_read(2'd1, v); chk("R5 busy visible", v, 16'h1000);
    #1 chk("R7 busy no irq", {15'd0, irq}, 16'd0);
    reg_write(2'd1, 16'h1000);
    reg_read(2'd1, v); chk("R5 busy not cleared", v, 16'h1000);
    @(negedge clk); busy = 1'b0;
    #1 rd = 1'b1; addr = 2'd1;
    #1 chk("R5 busy follows input", rdata, 16'h0000);
    @(negedge clk); rd = 1'b0;

    // sweep: every enable pattern against every event pattern on bits 0-4
    for (int en = 0; en < 32; en++) begin
      for (int p = 0; p < 32; p++) begin
        logic [15:0] code;
        code = '0;
        for (int k = 4; k >= 0; k--)
          if (((p & en) >> k) & 1) code = 16'(k + 1);
        reg_write(2'd0, 16'(en));
        reg_write(2'd1, 16'hFFFF);
        pulse(16'(p));
        reg_read(2'd1, v); chk("R2 sweep status", v, 16'(p));
        #1 chk(en == 0 ? "R8 sweep irq" : "R7 sweep irq",
               {15'd0, irq}, {15'd0, (p & en) != 0});
        reg_read(2'd2, v); chk("R9 sweep vector", v, code);
        s = 16'(p);
        if (code != 0) s[code - 1] = 1'b0;
        reg_read(2'd1, v); chk("R10 sweep clear", v, s);
      end
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule